// File: doc/BRIEF.md
# Cache Power-Domain Wake Sequencer

This block is a small hardware state machine that wakes a shared second-level cache and snoop-control power domain from power collapse. When it gets a start pulse it reads one bit of a power-status word. If that bit shows the domain is already powered, the block reports completion straight away and leaves its outputs alone. If not, it moves three control words through a fixed series of values, one write per step. The three words are the domain power-control word, a debug-reset override word and a clock-branch control word. Fixed waits, given in microseconds and counted in clock cycles, separate some of the steps.

The sequence first closes the logic head switch and powers the arrays. It then holds the debug reset and removes the memory clamp. Next it wakes the RAMs, enables the clock in software mode, releases the logic clamp, drops the debug reset and releases the logic reset. At the end it requests the processor supply and hands the clock branch to hardware control. A busy flag covers the run, and a one-cycle done pulse closes it.

Top module: `l2_pwrup_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) sets all three control words to 0, clears busy and done, and sends the machine to idle. A sequence in progress is abandoned.
- R2: A start accepted while idle with `pwr_status_i` bit 9 set gives `done_o` high one cycle later with `busy_o` low. None of the three control words changes. The other status bits have no effect on this choice.
- R3: A start accepted while idle with bit 9 clear writes these values in this order, each write changing one word: ctl=0x0010D700, ovr=0x00400000, ctl=0x00101700, ctl=0x00101703, clk=0x01, ctl=0x00101603, ovr=0x0, ctl=0x00100203, ctl=0x10100203, clk=0x03.
- R4: The first write appears on the outputs one cycle after the start edge. Each write that is not preceded by a wait follows the one before it by exactly one cycle.
- R5: The waits after the ovr=0x00400000 write, the ctl=0x00101703 write and the ctl=0x00101603 write each last 2 x `CYC_PER_US` cycles. This is the spacing from that write to the next one.
- R6: The wait after the ctl=0x00100203 write lasts 54 x `CYC_PER_US` cycles before ctl=0x10100203 appears.
- R7: `busy_o` is high from the cycle of the first write up to the cycle before the last write. It then falls in the same cycle that `done_o` rises. Busy only ends with done.
- R8: `done_o` is a single-cycle pulse. In a full run it coincides with the clk=0x03 write, and exactly one pulse is produced per accepted start.
- R9: While busy, a start pulse is ignored: the series of writes and their spacing are unchanged.
- R10: Status is sampled only when a start is accepted. A change of bit 9 during a run does not alter the run.
- R11: Outside a run each control word keeps its last value. A later run whose start sees bit 9 clear repeats the full series from those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to run the wake sequence |
| pwr_status_i | input | 32 | Domain power-status word; bit 9 set means already powered |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pwr_ctl_o | output | 32 | Domain power-control word |
| dbg_ovr_o | output | 32 | Debug-reset override word |
| clk_br_o | output | 32 | Clock-branch control word |

## Verification
The hardest case to reach from the ports is a start, or a change of status bit 9, that arrives in the middle of a run. It can land inside a long wait, where a faulty design might restart or skip ahead without any visible error at that moment. The bench handles this by logging every output change with its cycle number over the whole run. It injects a start pulse during the first short wait and sets bit 9 during the long wait, then compares the full log against the expected ten writes and their spacing. A second run from the end state, and a reset that cuts off a run in progress, show that the values hold between runs and that an abandoned run stays abandoned.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    localparam int WORD_W  = 32;
    localparam int STEP_W  = 4;
    localparam int N_STEPS = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_CTL,
        TGT_OVR,
        TGT_CLK
    } step_tgt_e;

    typedef enum logic [1:0] {
        WT_NONE,
        WT_SHORT,
        WT_LONG
    } wait_sel_e;

    typedef struct packed {
        step_tgt_e          tgt;
        logic [WORD_W-1:0]  val;
        wait_sel_e          wsel;
    } step_t;

    typedef struct packed {
        seq_state_e         state;
        logic [STEP_W-1:0]  step;
        logic [WORD_W-1:0]  ctl;
        logic [WORD_W-1:0]  ovr;
        logic [WORD_W-1:0]  clkb;
        logic               busy;
        logic               done;
    } seq_regs_t;

endpackage

// File: rtl/pwrup_steps.sv
module pwrup_steps
    import pwrup_pkg::*;
(
    input  logic [STEP_W-1:0] idx_i,
    output step_t             step_o,
    output logic              last_o
);

    always_comb begin
        step_o = '{tgt: TGT_CTL, val: '0, wsel: WT_NONE};
        unique case (idx_i)
            4'd0: step_o = '{tgt: TGT_CTL, val: 32'h0010_D700, wsel: WT_NONE};
            4'd1: step_o = '{tgt: TGT_OVR, val: 32'h0040_0000, wsel: WT_SHORT};
            4'd2: step_o = '{tgt: TGT_CTL, val: 32'h0010_1700, wsel: WT_NONE};
            4'd3: step_o = '{tgt: TGT_CTL, val: 32'h0010_1703, wsel: WT_SHORT};
            4'd4: step_o = '{tgt: TGT_CLK, val: 32'h0000_0001, wsel: WT_NONE};
            4'd5: step_o = '{tgt: TGT_CTL, val: 32'h0010_1603, wsel: WT_SHORT};
            4'd6: step_o = '{tgt: TGT_OVR, val: 32'h0000_0000, wsel: WT_NONE};
            4'd7: step_o = '{tgt: TGT_CTL, val: 32'h0010_0203, wsel: WT_LONG};
            4'd8: step_o = '{tgt: TGT_CTL, val: 32'h1010_0203, wsel: WT_NONE};
            4'd9: step_o = '{tgt: TGT_CLK, val: 32'h0000_0003, wsel: WT_NONE};
            default: step_o = '{tgt: TGT_CTL, val: '0, wsel: WT_NONE};
        endcase
    end

    assign last_o = (idx_i == STEP_W'(N_STEPS - 1));

endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R5, R6: an unloaded nonzero count falls by exactly one per cycle
    assert_countdown_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/l2_pwrup_seq.sv
module l2_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CYC_PER_US = 19,
    parameter int SHORT_US   = 2,
    parameter int LONG_US    = 54,
    parameter int STATUS_BIT = 9
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] pwr_status_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] pwr_ctl_o,
    output logic [WORD_W-1:0] dbg_ovr_o,
    output logic [WORD_W-1:0] clk_br_o
);

    localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
    localparam int LONG_CYC  = LONG_US * CYC_PER_US;
    localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    seq_regs_t         r_d, r_q;
    logic [STEP_W-1:0] idx;
    step_t             cur_step;
    logic              is_last;
    logic              fire;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_zero;
    logic              status_unused;

    assign status_unused = ^pwr_status_i;

    assign idx = (r_q.state == ST_IDLE) ? '0 : r_q.step;

    pwrup_steps i_steps (
        .idx_i  (idx),
        .step_o (cur_step),
        .last_o (is_last)
    );

    pwrup_timer #(.CNT_W(CNT_W)) i_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fire     = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (pwr_status_i[STATUS_BIT]) begin
                        r_d.done = 1'b1;
                    end else begin
                        fire     = 1'b1;
                        r_d.busy = 1'b1;
                    end
                end
            end
            ST_RUN:  fire = 1'b1;
            ST_WAIT: fire = t_zero;
            default: r_d.state = ST_IDLE;
        endcase

        if (fire) begin
            unique case (cur_step.tgt)
                TGT_CTL: r_d.ctl  = cur_step.val;
                TGT_OVR: r_d.ovr  = cur_step.val;
                TGT_CLK: r_d.clkb = cur_step.val;
                default: r_d.ctl  = r_q.ctl;
            endcase
            if (is_last) begin
                r_d.state = ST_IDLE;
                r_d.step  = '0;
                r_d.busy  = 1'b0;
                r_d.done  = 1'b1;
            end else begin
                r_d.step = STEP_W'(idx + 1'b1);
                unique case (cur_step.wsel)
                    WT_SHORT: begin
                        t_load    = 1'b1;
                        t_val     = CNT_W'(SHORT_CYC - 1);
                        r_d.state = ST_WAIT;
                    end
                    WT_LONG: begin
                        t_load    = 1'b1;
                        t_val     = CNT_W'(LONG_CYC - 1);
                        r_d.state = ST_WAIT;
                    end
                    default: r_d.state = ST_RUN;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '{state: ST_IDLE, step: '0, ctl: '0, ovr: '0,
                     clkb: '0, busy: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign pwr_ctl_o = r_q.ctl;
    assign dbg_ovr_o = r_q.ovr;
    assign clk_br_o  = r_q.clkb;

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> (pwr_ctl_o == '0 && dbg_ovr_o == '0 && clk_br_o == '0
                   && !busy_o && !done_o));

    assert_skip_no_change_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && start_i && pwr_status_i[STATUS_BIT]) |=>
        (done_o && !busy_o && $stable(pwr_ctl_o) && $stable(dbg_ovr_o)
         && $stable(clk_br_o)));

    assert_busy_ends_with_done_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |=> (busy_o || done_o));

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !start_i) |=>
        (!busy_o && $stable(pwr_ctl_o) && $stable(dbg_ovr_o) && $stable(clk_br_o)));

endmodule

// File: tb/test_l2_pwrup_seq.sv
module test_l2_pwrup_seq;

    localparam int C      = 4;
    localparam int SHORTC = 2 * C;
    localparam int LONGC  = 54 * C;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] status;
    logic        busy, done;
    logic [31:0] ctl, ovr, clkb;

    always #5 clk = ~clk;

    l2_pwrup_seq #(.CYC_PER_US(C)) i_l2_pwrup_seq (
        .clk_i        (clk),
        .rst_i        (rst),
        .start_i      (start),
        .pwr_status_i (status),
        .busy_o       (busy),
        .done_o       (done),
        .pwr_ctl_o    (ctl),
        .dbg_ovr_o    (ovr),
        .clk_br_o     (clkb)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    // change log
    bit          log_en = 1'b0;
    int          ev_cnt, done_cnt, done_cyc, busy_cnt;
    int          ev_cyc [16];
    logic [31:0] ev_ctl [16];
    logic [31:0] ev_ovr [16];
    logic [31:0] ev_clk [16];
    logic [31:0] p_ctl = '0, p_ovr = '0, p_clk = '0;

    always @(negedge clk) begin
        if (log_en) begin
            if ((ctl !== p_ctl || ovr !== p_ovr || clkb !== p_clk) && ev_cnt < 16) begin
                ev_cyc[ev_cnt] = cyc;
                ev_ctl[ev_cnt] = ctl;
                ev_ovr[ev_cnt] = ovr;
                ev_clk[ev_cnt] = clkb;
                ev_cnt++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (busy) busy_cnt++;
        end
        p_ctl = ctl;
        p_ovr = ovr;
        p_clk = clkb;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        ev_cnt = 0; done_cnt = 0; done_cyc = 0; busy_cnt = 0;
    endtask

    function automatic logic [31:0] x_ctl(int i);
        case (i)
            0, 1:       return 32'h0010_D700;
            2:          return 32'h0010_1700;
            3, 4:       return 32'h0010_1703;
            5, 6:       return 32'h0010_1603;
            7:          return 32'h0010_0203;
            default:    return 32'h1010_0203;
        endcase
    endfunction

    function automatic logic [31:0] x_ovr(int i, logic [31:0] ovr0);
        if (i == 0) return ovr0;
        if (i <= 5) return 32'h0040_0000;
        return 32'h0;
    endfunction

    function automatic logic [31:0] x_clk(int i, logic [31:0] clk0);
        if (i <= 3) return clk0;
        if (i <= 8) return 32'h1;
        return 32'h3;
    endfunction

    function automatic int x_gap(int i);
        case (i)
            2, 4, 6: return SHORTC;
            8:       return LONGC;
            default: return 1;
        endcase
    endfunction

    // full run, optional start poke during a short wait and bit-9 flip during the long wait
    task automatic run_full(input string tag, input logic [31:0] st,
                            input bit poke, input bit flip);
        int st_cyc;
        logic [31:0] ovr0, clk0;
        ovr0 = ovr; clk0 = clkb;
        clear_log();
        @(negedge clk);
        status = st; start = 1'b1; st_cyc = cyc; log_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 2000 && done_cnt == 0; n++) begin
            if (poke && n == 4) start = 1'b1;
            if (poke && n == 5) start = 1'b0;
            if (flip && n == 40) status = status | 32'h200;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        log_en = 1'b0;
        status = 32'h0;
        chk({tag, " R3"}, "event count", ev_cnt, 10);
        if (ev_cnt == 10) begin
            chk({tag, " R4"}, "first write latency", ev_cyc[0] - st_cyc, 1);
            for (int i = 0; i < 10; i++) begin
                chk({tag, " R3"}, $sformatf("ctl[%0d]", i), ev_ctl[i], x_ctl(i));
                chk({tag, " R3"}, $sformatf("ovr[%0d]", i), ev_ovr[i], x_ovr(i, ovr0));
                chk({tag, " R3"}, $sformatf("clk[%0d]", i), ev_clk[i], x_clk(i, clk0));
                if (i > 0) begin
                    if (i == 8)
                        chk({tag, " R6"}, "long wait", ev_cyc[i] - ev_cyc[i-1], x_gap(i));
                    else if (x_gap(i) != 1)
                        chk({tag, " R5"}, $sformatf("short wait %0d", i),
                            ev_cyc[i] - ev_cyc[i-1], x_gap(i));
                    else
                        chk({tag, " R4"}, $sformatf("gap %0d", i),
                            ev_cyc[i] - ev_cyc[i-1], 1);
                end
            end
            chk({tag, " R8"}, "done with last write", done_cyc, ev_cyc[9]);
        end
        chk({tag, " R8"}, "done pulses", done_cnt, 1);
        chk({tag, " R7"}, "busy cycles", busy_cnt, 5 + 60 * C);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; status = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ctl after reset", ctl, 0);
        chk("R1", "ovr after reset", ovr, 0);
        chk("R1", "clk after reset", clkb, 0);
        chk("R1", "busy/done after reset", {busy, done}, 0);
    endtask

    task automatic t_skip();
        logic [31:0] c0, o0, k0;
        c0 = ctl; o0 = ovr; k0 = clkb;
        clear_log();
        @(negedge clk);
        status = 32'h0000_0200; start = 1'b1; log_en = 1'b1;
        @(negedge clk);
        start = 1'b0; status = '0;
        chk("R2", "skip done", done, 1);
        chk("R2", "skip busy", busy, 0);
        @(negedge clk);
        chk("R8", "skip done pulse width", done, 0);
        repeat (3) @(negedge clk);
        log_en = 1'b0;
        chk("R2", "skip changes", ev_cnt, 0);
        chk("R2", "skip ctl", ctl, c0);
        chk("R2", "skip ovr", ovr, o0);
        chk("R2", "skip clk", clkb, k0);
    endtask

    task automatic t_hold();
        logic [31:0] c0, o0, k0;
        c0 = ctl; o0 = ovr; k0 = clkb;
        repeat (20) @(negedge clk);
        chk("R11", "hold ctl", ctl, c0);
        chk("R11", "hold ovr", ovr, o0);
        chk("R11", "hold clk", clkb, k0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        status = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "mid-run reset ctl", ctl, 0);
        chk("R1", "mid-run reset ovr", ovr, 0);
        chk("R1", "mid-run reset busy", busy, 0);
        repeat (LONGC + 20) @(negedge clk);
        chk("R1", "abandoned run ctl", ctl, 0);
        chk("R1", "abandoned run busy", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_skip();
        run_full("basic", 32'h0, 1'b0, 1'b0);
        t_hold();
        run_full("other-bits R2", 32'hFFFF_FDFF, 1'b0, 1'b0);
        run_full("rerun R11", 32'h0, 1'b0, 1'b0);
        run_full("start-while-busy R9", 32'h0, 1'b1, 1'b0);
        run_full("status-flip R10", 32'h0, 1'b0, 1'b1);
        t_skip();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule